// File: doc/BRIEF.md
# Four-Tributary Justifying Frame Multiplexer

This block merges four independent serial tributaries into one line bit stream organised as a 1176-bit multiframe. The multiframe has four subframes. Each subframe has six blocks of 49 bits, and each block is one overhead bit followed by 48 information bits. The information bits are taken from the tributaries in strict rotation, one bit each. The overhead bits carry frame alignment, multiframe alignment and a per-tributary stuff indication.

Each tributary writes into its own 16-bit elastic buffer. The write side is valid/ready. `trib_ready` is high whenever the buffer has room. The source cannot be stalled, because it is a plesiochronous bit stream, so a bit presented with `trib_valid` high while `trib_ready` is low is discarded and recorded. The line side has no back-pressure: one line bit is produced for each clock cycle in which `line_en` is high.

Once per frame, at the start of subframe i, the block compares the fill of buffer i against a programmable threshold. When the buffer is short, one fixed slot of that subframe carries a dummy bit instead of tributary data. This lets a slower tributary fit the fixed line rate.

Top module: `trib_stuff_mux`

## Requirements
- R1: Line bits advance only on `line_en`. One multiframe is 4 subframes × 6 blocks × 49 bits = 1176 line bits. `frame_sync` is high with exactly the first bit of each multiframe. `sub_idx` (0..3) and `blk_idx` (0..5) give the subframe and block of the bit currently on `ser_bit`.
- R2: The overhead bit (bit 0) of blocks 0..5 in every subframe is, in order: multiframe bit, stuff indicator, alignment 0, stuff indicator, stuff indicator, alignment 1. Alignment 0 is logic 0 and alignment 1 is logic 1.
- R3: The multiframe bits of subframes 0, 1, 2 and 3 are 0, 1, 1 and `m_x`.
- R4: Information bit k (k = 0..47, line bit k+1 of a block) carries tributary k mod 4. Each tributary's bits leave in the order they were accepted.
- R5: On the multiframe bit of subframe i, tributary i is marked stuffed for the rest of the frame if its buffer fill is below `stuff_thr` (an unsigned 5-bit value). All three stuff indicators of subframe i are 1 when the tributary is stuffed and 0 when it is not.
- R6: The stuff slot of tributary i is information bit i of block 5 in subframe i. When the tributary is stuffed, this slot is 0 and consumes no buffer bit. Otherwise it carries the next tributary bit. This gives at most one stuff per tributary per frame.
- R7: `ser_bit`, `sub_idx` and `blk_idx` change one clock after a cycle with `line_en` high and hold while it is low. `frame_sync` is a single-cycle pulse.
- R8: Each buffer holds 16 bits, and `trib_ready` is low only when it is full. A write offered while the buffer is full is dropped and sets the sticky `ovf_flag` bit for that tributary.
- R9: A data slot that finds its buffer empty sends 0 and sets the sticky `udf_flag` bit for that tributary.
- R10: After reset, `ser_bit`, `frame_sync` and all flags are 0 and every `trib_ready` is 1. The first line bit produced is bit 0 of subframe 0, block 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_en | input | 1 | Line-rate enable; one line bit per high cycle |
| m_x | input | 1 | Value of the last multiframe bit |
| stuff_thr | input | 5 | Fill threshold below which a tributary is stuffed |
| trib_valid | input | 4 | Per-tributary write strobe |
| trib_data | input | 4 | Per-tributary write bit |
| trib_ready | output | 4 | Per-tributary buffer not full |
| ser_bit | output | 1 | Line bit |
| frame_sync | output | 1 | High with the first bit of a multiframe |
| sub_idx | output | 2 | Subframe of the current line bit |
| blk_idx | output | 3 | Block of the current line bit |
| ovf_flag | output | 4 | Sticky dropped-write flags |
| udf_flag | output | 4 | Sticky empty-read flags |

## Verification
The embedded properties watch, on every cycle, the rules that hold at any moment: buffer fill never exceeds its depth, both error flags are set and stay set, at most one buffer is read per line bit and none while `line_en` is low, and a stuff decision changes only at its subframe's multiframe bit. The bench has to show the contents of the stream. It decodes every line bit into its overhead and per-tributary data and compares the result against its own model of buffer fill and accepted bits. That covers the overhead order, the stuff decisions predicted from the threshold, the dummy slot, the data that was dropped, and the behaviour across idle gaps in `line_en`.

// File: rtl/tsm_pkg.sv
`timescale 1ns/1ps
package tsm_pkg;
  typedef enum logic [2:0] {
    SK_MFRM,
    SK_STUFFC,
    SK_ALIGN0,
    SK_ALIGN1,
    SK_DATA
  } slot_e;
endpackage

// File: rtl/tsm_trib_fifo.sv
`timescale 1ns/1ps
module tsm_trib_fifo #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          wr_data,
  output logic          wr_ready,
  input  logic          rd_en,
  output logic          rd_data,
  output logic [CW-1:0] fill,
  output logic          ovf,
  output logic          udf
);
  localparam int AW = $clog2(DEPTH);

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             full, empty, wr_fire, rd_fire;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign wr_fire = wr_valid && !full;
  assign rd_fire = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
      udf <= 1'b0;
    end else begin
      if (wr_fire) wp <= wp + AW'(1);
      if (rd_fire) rp <= rp + AW'(1);
      case ({wr_fire, rd_fire})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
      if (wr_valid && full) ovf <= 1'b1;
      if (rd_en && empty)   udf <= 1'b1;
    end
  end

  assign wr_ready = !full;
  assign rd_data  = empty ? 1'b0 : mem[rp];
  assign fill     = cnt;

  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));
  a_r8_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> ovf);
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);
  a_r9_udf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fill == '0) |=> udf);
  a_r9_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    udf |=> udf);
endmodule

// File: rtl/tsm_frame_seq.sv
`timescale 1ns/1ps
module tsm_frame_seq
  import tsm_pkg::*;
#(
  parameter int NSUB   = 4,
  parameter int NBLK   = 6,
  parameter int BLKLEN = 49,
  parameter int NTRIB  = 4,
  parameter int SUB_W  = 2,
  parameter int BLK_W  = 3,
  parameter int POS_W  = 6,
  parameter int TW     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [SUB_W-1:0] sub_o,
  output logic [BLK_W-1:0] blk_o,
  output slot_e            kind_o,
  output logic [TW-1:0]    trib_o,
  output logic             stuff_slot_o,
  output logic             sub_start_o,
  output logic             frm_start_o
);
  logic [POS_W-1:0] pos_q, info, info_mod;
  logic [BLK_W-1:0] blk_q;
  logic [SUB_W-1:0] sub_q;
  logic             last_pos, last_blk, last_sub;

  assign last_pos = (pos_q == POS_W'(BLKLEN - 1));
  assign last_blk = (blk_q == BLK_W'(NBLK - 1));
  assign last_sub = (sub_q == SUB_W'(NSUB - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      blk_q <= '0;
      sub_q <= '0;
    end else if (adv) begin
      if (last_pos) begin
        pos_q <= '0;
        if (last_blk) begin
          blk_q <= '0;
          sub_q <= last_sub ? '0 : sub_q + SUB_W'(1);
        end else begin
          blk_q <= blk_q + BLK_W'(1);
        end
      end else begin
        pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  always_comb begin
    kind_o = SK_DATA;
    if (pos_q == '0) begin
      unique case (blk_q)
        BLK_W'(0): kind_o = SK_MFRM;
        BLK_W'(2): kind_o = SK_ALIGN0;
        BLK_W'(5): kind_o = SK_ALIGN1;
        default:   kind_o = SK_STUFFC;
      endcase
    end
  end

  assign info         = pos_q - POS_W'(1);
  assign info_mod     = info % POS_W'(NTRIB);
  assign trib_o       = info_mod[TW-1:0];
  assign stuff_slot_o = (kind_o == SK_DATA) && last_blk && (info == POS_W'(sub_q));
  assign sub_start_o  = (pos_q == '0) && (blk_q == '0);
  assign frm_start_o  = sub_start_o && (sub_q == '0);
  assign sub_o        = sub_q;
  assign blk_o        = blk_q;

  a_r1_frame_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_pos && last_blk && last_sub) |=> frm_start_o);
  a_r1_block_range: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_q < BLK_W'(NBLK)) && (pos_q < POS_W'(BLKLEN)));
endmodule

// File: rtl/tsm_stuff_ctl.sv
`timescale 1ns/1ps
module tsm_stuff_ctl #(
  parameter int NTRIB = 4,
  parameter int CW    = 5,
  parameter int SUB_W = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      latch,
  input  logic [SUB_W-1:0]          sub,
  input  logic [NTRIB-1:0][CW-1:0]  fill,
  input  logic [CW-1:0]             thr,
  output logic [NTRIB-1:0]          stuff_q
);
  for (genvar i = 0; i < NTRIB; i++) begin : g_dec
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stuff_q[i] <= 1'b0;
      end else if (latch && sub == SUB_W'(i)) begin
        stuff_q[i] <= (fill[i] < thr);
      end
    end
  end

  a_r5_decision_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(latch) |-> $stable(stuff_q));
endmodule

// File: rtl/trib_stuff_mux.sv
`timescale 1ns/1ps
module trib_stuff_mux
  import tsm_pkg::*;
#(
  parameter int NTRIB  = 4,
  parameter int DEPTH  = 16,
  parameter int BLKLEN = 49,
  localparam int NSUB  = NTRIB,
  localparam int NBLK  = 6,
  localparam int CW    = $clog2(DEPTH + 1),
  localparam int SUB_W = $clog2(NSUB),
  localparam int BLK_W = $clog2(NBLK),
  localparam int POS_W = $clog2(BLKLEN),
  localparam int TW    = $clog2(NTRIB)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_en,
  input  logic             m_x,
  input  logic [CW-1:0]    stuff_thr,
  input  logic [NTRIB-1:0] trib_valid,
  input  logic [NTRIB-1:0] trib_data,
  output logic [NTRIB-1:0] trib_ready,
  output logic             ser_bit,
  output logic             frame_sync,
  output logic [SUB_W-1:0] sub_idx,
  output logic [BLK_W-1:0] blk_idx,
  output logic [NTRIB-1:0] ovf_flag,
  output logic [NTRIB-1:0] udf_flag
);
  logic [SUB_W-1:0]         sub;
  logic [BLK_W-1:0]         blk;
  slot_e                    kind;
  logic [TW-1:0]            trib;
  logic                     stuff_slot, sub_start, frm_start;
  logic [NTRIB-1:0]         head, rd_en, stuff_q;
  logic [NTRIB-1:0][CW-1:0] fill;
  logic                     slot_bit, skip;

  tsm_frame_seq #(
    .NSUB(NSUB), .NBLK(NBLK), .BLKLEN(BLKLEN), .NTRIB(NTRIB),
    .SUB_W(SUB_W), .BLK_W(BLK_W), .POS_W(POS_W), .TW(TW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .adv(line_en),
    .sub_o(sub), .blk_o(blk), .kind_o(kind), .trib_o(trib),
    .stuff_slot_o(stuff_slot), .sub_start_o(sub_start), .frm_start_o(frm_start)
  );

  for (genvar t = 0; t < NTRIB; t++) begin : g_trib
    tsm_trib_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(trib_valid[t]), .wr_data(trib_data[t]), .wr_ready(trib_ready[t]),
      .rd_en(rd_en[t]), .rd_data(head[t]), .fill(fill[t]),
      .ovf(ovf_flag[t]), .udf(udf_flag[t])
    );
  end

  tsm_stuff_ctl #(.NTRIB(NTRIB), .CW(CW), .SUB_W(SUB_W)) u_stuff (
    .clk(clk), .rst_n(rst_n), .latch(line_en && sub_start),
    .sub(sub), .fill(fill), .thr(stuff_thr), .stuff_q(stuff_q)
  );

  assign skip = stuff_slot && stuff_q[sub];

  always_comb begin
    for (int t = 0; t < NTRIB; t++) begin
      rd_en[t] = line_en && (kind == SK_DATA) && !skip && (trib == TW'(t));
    end
  end

  always_comb begin
    slot_bit = 1'b0;
    unique case (kind)
      SK_MFRM: begin
        if (sub == '0)                         slot_bit = 1'b0;
        else if (sub == SUB_W'(NSUB - 1))      slot_bit = m_x;
        else                                   slot_bit = 1'b1;
      end
      SK_STUFFC: slot_bit = stuff_q[sub];
      SK_ALIGN0: slot_bit = 1'b0;
      SK_ALIGN1: slot_bit = 1'b1;
      default:   slot_bit = skip ? 1'b0 : head[trib];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ser_bit    <= 1'b0;
      frame_sync <= 1'b0;
      sub_idx    <= '0;
      blk_idx    <= '0;
    end else begin
      frame_sync <= line_en && frm_start;
      if (line_en) begin
        ser_bit <= slot_bit;
        sub_idx <= sub;
        blk_idx <= blk;
      end
    end
  end

  a_r6_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_en));
  a_r7_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !line_en |-> (rd_en == '0));
  a_r7_sync_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> !frame_sync);
  a_r1_sync_index: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |-> (sub_idx == '0 && blk_idx == '0));
endmodule

// File: tb/sim_trib_stuff_mux.sv
`timescale 1ns/1ps
module sim_trib_stuff_mux;
  localparam int FRM = 1176;

  logic       clk, rst_n, line_en, m_x;
  logic [4:0] stuff_thr;
  logic [3:0] trib_valid, trib_data, trib_ready, ovf_flag, udf_flag;
  logic       ser_bit, frame_sync;
  logic [1:0] sub_idx;
  logic [2:0] blk_idx;

  int  total, bad;
  bit  done;
  bit  exp_q [4][$];
  int  est [4];
  int  snap [4];

  trib_stuff_mux u0 (
    .clk(clk), .rst_n(rst_n), .line_en(line_en), .m_x(m_x), .stuff_thr(stuff_thr),
    .trib_valid(trib_valid), .trib_data(trib_data), .trib_ready(trib_ready),
    .ser_bit(ser_bit), .frame_sync(frame_sync), .sub_idx(sub_idx), .blk_idx(blk_idx),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; line_en = 1'b0; m_x = 1'b0; stuff_thr = '0;
    trib_valid = '0; trib_data = '0;
    for (int t = 0; t < 4; t++) begin
      exp_q[t].delete(); est[t] = 0; snap[t] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic prefill(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      for (int t = 0; t < 4; t++) begin
        bit v;
        v = 1'($urandom_range(0, 1));
        trib_valid[t] = 1'b1; trib_data[t] = v;
        exp_q[t].push_back(v); est[t]++;
      end
      @(posedge clk);
    end
    @(negedge clk); trib_valid = '0;
    for (int t = 0; t < 4; t++) snap[t] = est[t];
  endtask

  // Decodes every line bit against the framing rules and the bench's own fill model.
  task automatic run_frames(input int nfr, input bit feed, input int thr_v,
                            input bit mx_v, input bit gaps, output int nst);
    int e_sync, e_idx, e_oh, e_m, e_c, e_data, e_slot, e_hold;
    bit [3:0] cur;
    e_sync = 0; e_idx = 0; e_oh = 0; e_m = 0; e_c = 0; e_data = 0; e_slot = 0; e_hold = 0;
    nst = 0; cur = '0;
    stuff_thr = 5'(thr_v); m_x = mx_v;
    @(negedge clk); line_en = 1'b1; trib_valid = '0;
    for (int n = 0; n < nfr * FRM; n++) begin
      int p, sf, r, blk, b;
      @(posedge clk); @(negedge clk);
      p = n % FRM; sf = p / 294; r = p % 294; blk = r / 49; b = r % 49;
      if (frame_sync !== (p == 0)) e_sync++;
      if (sub_idx !== 2'(sf) || blk_idx !== 3'(blk)) e_idx++;
      if (b == 0) begin
        case (blk)
          0: begin
            bit em;
            em = (sf == 0) ? 1'b0 : (sf == 3) ? mx_v : 1'b1;
            if (ser_bit !== em) e_m++;
            cur[sf] = (snap[sf] < thr_v);
            if (cur[sf]) nst++;
          end
          2: if (ser_bit !== 1'b0) e_oh++;
          5: if (ser_bit !== 1'b1) e_oh++;
          default: if (ser_bit !== cur[sf]) e_c++;
        endcase
      end else begin
        int j, t;
        bit eb;
        j = b - 1; t = j % 4;
        if (blk == 5 && j == sf && cur[sf]) begin
          if (ser_bit !== 1'b0) e_slot++;
        end else begin
          eb = (exp_q[t].size() == 0) ? 1'b0 : exp_q[t].pop_front();
          if (ser_bit !== eb) e_data++;
          if (est[t] > 0) est[t]--;
        end
      end
      for (int t = 0; t < 4; t++) snap[t] = est[t];
      if (gaps && (n % 7) == 3) begin
        logic hb; logic [1:0] hs; logic [2:0] hk;
        line_en = 1'b0; trib_valid = '0;
        hb = ser_bit; hs = sub_idx; hk = blk_idx;
        repeat (2) begin
          @(posedge clk); @(negedge clk);
          if (ser_bit !== hb || sub_idx !== hs || blk_idx !== hk || frame_sync !== 1'b0) e_hold++;
        end
        line_en = 1'b1;
      end
      for (int t = 0; t < 4; t++) begin
        if (feed && est[t] < 8) begin
          bit v;
          v = 1'($urandom_range(0, 1));
          trib_valid[t] = 1'b1; trib_data[t] = v;
          exp_q[t].push_back(v); est[t]++;
        end else begin
          trib_valid[t] = 1'b0;
        end
      end
    end
    line_en = 1'b0; trib_valid = '0;
    chk(e_sync == 0, "R1", "frame_sync misplacements", e_sync, 0);
    chk(e_idx == 0, "R1", "index mismatches", e_idx, 0);
    chk(e_oh == 0, "R2", "alignment bit errors", e_oh, 0);
    chk(e_m == 0, "R3", "multiframe bit errors", e_m, 0);
    chk(e_c == 0, "R5", "stuff indicator errors", e_c, 0);
    chk(e_data == 0, "R4", "tributary data errors", e_data, 0);
    chk(e_slot == 0, "R6", "dummy slot errors", e_slot, 0);
    if (gaps) chk(e_hold == 0, "R7", "output changed while idle", e_hold, 0);
  endtask

  task automatic test_reset();
    do_reset();
    chk(ser_bit === 1'b0 && frame_sync === 1'b0, "R10", "line outputs after reset",
        {ser_bit, frame_sync}, 0);
    chk(ovf_flag === 4'h0 && udf_flag === 4'h0, "R10", "flags after reset",
        {ovf_flag, udf_flag}, 0);
    chk(trib_ready === 4'hF, "R10", "ready after reset", trib_ready, 15);
  endtask

  task automatic test_no_stuff();
    int nst;
    do_reset(); prefill(8);
    run_frames(2, 1'b1, 0, 1'b0, 1'b0, nst);
    chk(nst == 0, "R5", "stuffs with threshold 0", nst, 0);
    chk(udf_flag === 4'h0 && ovf_flag === 4'h0, "R9", "flags in fed run",
        {ovf_flag, udf_flag}, 0);
  endtask

  task automatic test_all_stuff();
    int nst;
    do_reset(); prefill(8);
    run_frames(2, 1'b1, 31, 1'b1, 1'b1, nst);
    chk(nst == 8, "R6", "one stuff per tributary per frame", nst, 8);
    chk(udf_flag === 4'h0, "R9", "no underflow while stuffing", udf_flag, 0);
  endtask

  task automatic test_mixed();
    int nst;
    do_reset(); prefill(8);
    run_frames(3, 1'b1, 8, 1'b1, 1'b0, nst);
    chk(nst > 0 && nst < 12, "R5", "mixed stuff count at threshold 8", nst, 6);
  endtask

  task automatic test_underflow();
    int nst;
    do_reset();
    run_frames(1, 1'b0, 0, 1'b0, 1'b0, nst);
    chk(udf_flag === 4'hF, "R9", "underflow flags", udf_flag, 15);
    chk(ovf_flag === 4'h0, "R9", "overflow flags stay clear", ovf_flag, 0);
  endtask

  task automatic test_overflow();
    int nst;
    do_reset(); prefill(16);
    chk(trib_ready === 4'h0, "R8", "ready when full", trib_ready, 0);
    chk(ovf_flag === 4'h0, "R8", "no overflow at exactly full", ovf_flag, 0);
    trib_valid = 4'hF; trib_data = 4'hF;
    @(posedge clk); @(negedge clk); trib_valid = '0;
    chk(ovf_flag === 4'hF, "R8", "overflow flags after write to full", ovf_flag, 15);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(ovf_flag === 4'hF, "R8", "overflow flags sticky", ovf_flag, 15);
    run_frames(1, 1'b0, 0, 1'b0, 1'b0, nst);
    chk(udf_flag === 4'hF, "R9", "underflow after draining", udf_flag, 15);
  endtask

  initial begin
    total = 0; bad = 0; done = 1'b0;
    test_reset();
    test_no_stuff();
    test_all_stuff();
    test_mixed();
    test_underflow();
    test_overflow();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule